// File: doc/BRIEF.md
# Monochrome Tile to Grayscale Expander

This block turns one 8x8 monochrome tile into the byte stream a 16-level grayscale panel controller takes for an 8-row, 8-pixel window. Each tile arrives as column bytes, where bit i of a byte is row i and bit 0 is the top row. The block stores the whole tile and then emits it row by row, packing two 4-bit pixels into each output byte. A lit pixel becomes level 15 and a dark pixel becomes level 0.

Two densities are supported. In full mode the tile takes eight input bytes, read as four pairs. In each pair the first byte feeds the upper nibble and the second byte feeds the lower nibble. In half mode the tile takes four input bytes, and each pixel is doubled horizontally into a whole output byte. Either way a tile always produces 32 output bytes.

Both data sides use valid/ready. A byte moves only in a cycle where valid and ready are both high. The producer may hold `in_valid` high at any time, but `in_ready` stays low from the moment the last input byte of a tile is taken until the last output byte has been taken. The consumer may drop `out_ready` in any cycle. While it is low, the pending output byte and `out_valid` are held unchanged.

Top module: `tile_gray_expander`

## Requirements
- R1: A synchronous active-high reset clears the stored tile and any partly loaded tile. After reset, `in_ready` is 1 and `out_valid` is 0, and the next accepted byte is taken as the first byte of a new tile.
- R2: In full mode, input bytes 2j and 2j+1 form pair j, for j = 0..3. Bit i of a byte is the pixel in row i, with bit 0 as row 0.
- R3: In full mode, the output byte at index 4i+j has bits [7:4] = 0xF when bit i of pair j's first byte is set, and bits [3:0] = 0xF when bit i of its second byte is set. A clear bit gives a nibble of 0.
- R4: In half mode, a tile is four input bytes. The output byte at index 4i+j is 0xFF when bit i of input byte j is set, and 0x00 otherwise.
- R5: Each tile yields exactly 32 output bytes, leaving in index order 0 to 31.
- R6: `out_valid` stays low until every input byte of the tile has been accepted. `in_ready` is low whenever `out_valid` is high.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values into the next cycle.
- R8: `half_mode` is sampled with the first input byte of a tile (1 = half mode). Changes to it later in the same tile have no effect on that tile's byte count or output.
- R9: If `in_valid` is held high while a tile is draining, the next tile's first byte is accepted no earlier than the cycle after the last output handshake, and it is accepted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| half_mode | input | 1 | 1 selects half density; sampled with a tile's first byte |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Tile column byte, bit 0 = row 0 |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Packed pixel pair (or a doubled pixel) for the current index |

## Verification
Two functions can fall on the same clock edge: taking the last output byte of one tile and accepting the first input byte of the next. The bench provokes this by holding `in_valid` high, with the next tile's first byte on `in_data`, for the whole drain. It then checks that `in_ready` stayed low until the final output handshake, rose in the following cycle, and that the second tile's output matches a tile built from that held byte exactly once. A second overlap is a `half_mode` change that lands in the same cycle as a later input byte. That case is judged by the tile length and the doubled output pattern.

// File: rtl/tge_pkg.sv
package tge_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_EMIT = 1'b1
  } phase_t;
endpackage

// File: rtl/tge_capture.sv
module tge_capture #(
  parameter int ROWS  = 8,
  parameter int SLOTS = 8,
  parameter int CW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wrap,
  input  logic [ROWS-1:0]       wr_data,
  output logic [CW-1:0]         count,
  output logic [SLOTS*ROWS-1:0] slots_flat
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (wr_en) count <= wrap ? '0 : count + 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [ROWS-1:0] col_q;
    always_ff @(posedge clk) begin
      if (rst)                            col_q <= '0;
      else if (wr_en && count == CW'(g))  col_q <= wr_data;
    end
    assign slots_flat[g*ROWS +: ROWS] = col_q;
  end
endmodule

// File: rtl/tge_mapper.sv
module tge_mapper #(
  parameter int ROWS  = 8,
  parameter int PAIRS = 4,
  parameter int NIB_W = 4
) (
  input  logic [2*PAIRS*ROWS-1:0]       slots_flat,
  input  logic                          half,
  input  logic [$clog2(ROWS*PAIRS)-1:0] idx,
  output logic [2*NIB_W-1:0]            pix_byte
);
  localparam int IW = $clog2(ROWS*PAIRS);
  localparam int PW = $clog2(PAIRS);

  logic [IW-PW-1:0] row;
  logic [PW-1:0]    col;
  logic [PAIRS-1:0] hi_bit, lo_bit, dup_bit;

  assign row = idx[IW-1:PW];
  assign col = idx[PW-1:0];

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    logic [ROWS-1:0] first_b, second_b, single_b;
    assign first_b    = slots_flat[(2*j)*ROWS   +: ROWS];
    assign second_b   = slots_flat[(2*j+1)*ROWS +: ROWS];
    assign single_b   = slots_flat[j*ROWS       +: ROWS];
    assign hi_bit[j]  = first_b[row];
    assign lo_bit[j]  = second_b[row];
    assign dup_bit[j] = single_b[row];
  end

  always_comb begin
    if (half) pix_byte = {(2*NIB_W){dup_bit[col]}};
    else      pix_byte = {{NIB_W{hi_bit[col]}}, {NIB_W{lo_bit[col]}}};
  end
endmodule

// File: rtl/tge_emitter.sv
module tge_emitter #(
  parameter int OUT_BYTES = 32,
  parameter int IW        = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      idx       <= '0;
    end else if (start) begin
      out_valid <= 1'b1;
      idx       <= '0;
    end else if (out_valid && out_ready) begin
      if (idx == IW'(OUT_BYTES-1)) begin
        out_valid <= 1'b0;
        idx       <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tile_gray_expander.sv
module tile_gray_expander #(
  parameter int ROWS  = 8,
  parameter int PAIRS = 4,
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 half_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ROWS-1:0]      in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*NIB_W-1:0]   out_data
);
  import tge_pkg::*;

  localparam int SLOTS     = 2*PAIRS;
  localparam int OUT_BYTES = ROWS*PAIRS;
  localparam int BYTE_W    = 2*NIB_W;
  localparam int IW        = $clog2(OUT_BYTES);
  localparam int CW        = $clog2(SLOTS+1);

  phase_t                phase;
  logic                  in_fire, last_in, eff_half, mode_q;
  logic [CW-1:0]         count;
  logic [SLOTS*ROWS-1:0] slots_flat;
  logic [IW-1:0]         idx;
  logic                  emit_valid;

  assign phase    = emit_valid ? PH_EMIT : PH_LOAD;
  assign in_ready = (phase == PH_LOAD);
  assign in_fire  = in_valid && in_ready;
  assign eff_half = (count == '0) ? half_mode : mode_q;
  assign last_in  = in_fire &&
                    (count == (eff_half ? CW'(PAIRS-1) : CW'(SLOTS-1)));

  always_ff @(posedge clk) begin
    if (rst)                          mode_q <= 1'b0;
    else if (in_fire && count == '0)  mode_q <= half_mode;
  end

  tge_capture #(.ROWS(ROWS), .SLOTS(SLOTS), .CW(CW)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (in_fire),
    .wrap       (last_in),
    .wr_data    (in_data),
    .count      (count),
    .slots_flat (slots_flat)
  );

  tge_emitter #(.OUT_BYTES(OUT_BYTES), .IW(IW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .start     (last_in),
    .out_ready (out_ready),
    .out_valid (emit_valid),
    .idx       (idx)
  );

  tge_mapper #(.ROWS(ROWS), .PAIRS(PAIRS), .NIB_W(NIB_W)) u_map (
    .slots_flat (slots_flat),
    .half       (mode_q),
    .idx        (idx),
    .pix_byte   (out_data)
  );

  assign out_valid = emit_valid;
endmodule

// File: rtl/tge_checker.sv
module tge_checker #(
  parameter int BYTE_W    = 8,
  parameter int OUT_BYTES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              mode_q
);
  localparam int HW = BYTE_W/2;
  localparam int OW = $clog2(OUT_BYTES);

  logic [OW-1:0] ocnt;
  always_ff @(posedge clk) begin
    if (rst)                         ocnt <= '0;
    else if (out_valid && out_ready) ocnt <= (ocnt == OW'(OUT_BYTES-1)) ? '0 : ocnt + 1'b1;
  end

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);  // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R7
  AST_FULL_NIBBLES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mode_q) |->
      ((out_data[BYTE_W-1:HW] == '0 || out_data[BYTE_W-1:HW] == '1) &&
       (out_data[HW-1:0] == '0 || out_data[HW-1:0] == '1)));  // R3
  AST_HALF_BYTES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q) |-> (out_data == '0 || out_data == '1));  // R4
  AST_TILE_LEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (ocnt == '0));  // R5
endmodule

bind tile_gray_expander tge_checker #(.BYTE_W(BYTE_W), .OUT_BYTES(OUT_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .mode_q    (mode_q)
);

// File: tb/sim_tile_gray_expander.sv
module sim_tile_gray_expander;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] tile [0:7];

  always #2.5 clk = ~clk;

  tile_gray_expander u0 (
    .clk(clk), .rst(rst), .half_mode(half_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k, input bit half);
    int i = k / 4;
    int j = k % 4;
    logic [7:0] a = tile[2*j];
    logic [7:0] b = tile[2*j+1];
    logic [7:0] s = tile[j];
    if (half) return s[i] ? 8'hFF : 8'h00;
    return {a[i] ? 4'hF : 4'h0, b[i] ? 4'hF : 4'h0};
  endfunction

  // Called at a negedge; returns at the negedge after the byte was taken.
  task automatic push(input logic [7:0] b, input bit mode);
    in_valid  = 1'b1;
    in_data   = b;
    half_mode = mode;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input bit half, input bit stall, input string req);
    int k = 0;
    bit tog = 1'b0;
    while (k < 32) begin
      out_ready = !stall || tog;
      tog = !tog;
      if (out_valid && !out_ready) begin
        logic [7:0] held = out_data;
        @(negedge clk);
        chk(out_valid && out_data == held, "R7 hold under stall", out_data, held);
        continue;
      end
      if (out_valid) begin
        chk(out_data == exp_byte(k, half), req, out_data, exp_byte(k, half));
        chk(!in_ready, "R6 in_ready low while emitting", in_ready, 0);
        k++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R5 exactly 32 bytes then idle", out_valid, 0);
  endtask

  task automatic send_tile(input bit first_mode, input bit rest_mode,
                           input bit stall, input string req);
    int n = first_mode ? 4 : 8;
    for (int b = 0; b < n; b++) begin
      if (b == n-1) chk(!out_valid && in_ready, "R6 no output before last byte", out_valid, 0);
      push(tile[b], (b == 0) ? first_mode : rest_mode);
    end
    chk(out_valid, "R6 output starts after last byte", out_valid, 1);
    drain(first_mode, stall, req);
  endtask

  task automatic t_reset_state;
    chk(in_ready && !out_valid, "R1 reset state", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic t_full_patterns;
    tile = '{8'h01, 8'h80, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'hC3, 8'h3C};
    send_tile(1'b0, 1'b0, 1'b0, "R2 R3 mixed full tile");
    tile = '{8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00};
    send_tile(1'b0, 1'b0, 1'b0, "R3 solid columns");
  endtask

  task automatic t_half_pattern;
    tile = '{8'h83, 8'h5A, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_tile(1'b1, 1'b1, 1'b0, "R4 half-density tile");
  endtask

  task automatic t_backpressure;
    tile = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF1};
    send_tile(1'b0, 1'b0, 1'b1, "R7 R3 stalled drain");
  endtask

  task automatic t_mode_change;
    tile = '{8'hE7, 8'h18, 8'h66, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00};
    send_tile(1'b1, 1'b0, 1'b0, "R8 mode held from first byte");
    tile = '{8'h11, 8'h22, 8'h44, 8'h88, 8'h11, 8'h22, 8'h44, 8'h88};
    send_tile(1'b0, 1'b1, 1'b0, "R8 full mode kept after toggle");
  endtask

  task automatic t_reset_mid_tile;
    push(8'hFF, 1'b0);
    push(8'hFF, 1'b0);
    push(8'hFF, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready && !out_valid, "R1 reset drops partial tile", {in_ready, out_valid}, 2'b10);
    tile = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40};
    send_tile(1'b0, 1'b0, 1'b0, "R1 fresh tile after reset");
  endtask

  task automatic t_overlap;
    logic [7:0] nxt [0:7];
    nxt  = '{8'hA5, 8'h3C, 8'hC3, 8'h5A, 8'h81, 8'h7E, 8'h24, 8'hDB};
    tile = '{8'h0F, 8'hF0, 8'h33, 8'hCC, 8'h55, 8'hAA, 8'h01, 8'hFE};
    for (int b = 0; b < 8; b++) push(tile[b], 1'b0);
    in_valid = 1'b1;
    in_data  = nxt[0];
    drain(1'b0, 1'b1, "R9 first tile while input pending");
    chk(in_ready, "R9 input ready right after last output", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    tile = nxt;
    for (int b = 1; b < 8; b++) begin
      if (b == 7) chk(!out_valid, "R9 held byte taken once", out_valid, 0);
      push(tile[b], 1'b0);
    end
    chk(out_valid, "R9 second tile complete", out_valid, 1);
    drain(1'b0, 1'b0, "R9 second tile content");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_full_patterns();
    t_half_pattern();
    t_backpressure();
    t_mode_change();
    t_reset_mid_tile();
    t_overlap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule